// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block collects message-signalled interrupts for a PCIe root complex and folds them into a single level interrupt for the host. An endpoint raises an event by writing a vector number to a doorbell register. The block decodes that number and sets the matching bit in a 256-entry pending array. It drives its one interrupt output whenever some pending vector is also unmasked.

Software sees the pending and mask arrays as eight 32-bit words each on a simple register bus. It finds the source by scanning the pending words and clears an event by writing a one to its bit. Doorbell events arrive on two paths. One is a register-bus write to the doorbell offset. The other is a dedicated inbound port that carries writes the link layer has already decoded. Both paths may fire in the same cycle.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: A register-bus write to byte offset 0x7C with data v, where v < 256, sets pending bit v.
- R2: A cycle with `ib_db_valid` high and `ib_db_vector` = v, where v < 256, sets pending bit v. A bus doorbell in the same cycle also takes effect.
- R3: A doorbell value of 256 or more, on either path, sets no pending bit.
- R4: Vector n is held in bit n%32 of the pending word at byte offset 0x80 + 4*(n/32). Offsets 0x80 to 0x9C are pending words 0 to 7.
- R5: Writing a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. A pending bit never clears without such a write.
- R6: The mask words sit at offsets 0xA0 to 0xBC and use the same bank and bit layout. A 1 bit unmasks its vector. A written word reads back unchanged.
- R7: Synchronous active-high reset clears every pending and mask bit and drives `irq_out` low.
- R8: `irq_out` equals the OR over all (pending AND mask) bits, taken from the state one clock earlier. It therefore changes on the clock edge after the one that changed pending or mask state.
- R9: If a doorbell and a clearing write hit the same bit in one cycle, the bit ends up set.
- R10: `reg_rdata` shows the word addressed by a read on the clock edge that samples `reg_rd`. It reads 0 for any other offset, including 0x7C and offsets that are not word aligned. It reads 0 in cycles without a read.
- R11: A masked vector still latches and reports its pending bit. Unmasking it later raises `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ib_db_valid | input | 1 | Decoded inbound doorbell write present |
| ib_db_vector | input | 32 | Vector number carried by the inbound doorbell |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
Pending and mask state change on the edge that samples a write or doorbell, so a read issued on the next cycle already sees the new value. Read data is due one edge after `reg_rd`. The interrupt output is due one edge after the state change, so it lags the stimulus by two edges. The bench drives on falling edges and samples `reg_rdata` on the falling edge right after the reading edge. It first checks `irq_out` on the falling edge after the state change, where the old level must still show. It then checks again one cycle later for the new level. A bench model of both arrays supplies every expected value, under random traffic and the directed corner cases.

// File: rtl/msi_dbc_pkg.sv
package msi_dbc_pkg;
    parameter int unsigned NUM_VEC = 256;
    parameter int unsigned BANK_W  = 32;
    parameter int unsigned ADDR_W  = 8;
    parameter int unsigned DATA_W  = 32;

    localparam int unsigned NUM_BANKS  = NUM_VEC / BANK_W;
    localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int unsigned VEC_IDX_W  = $clog2(NUM_VEC);
    localparam int unsigned WORD_W     = ADDR_W - 2;

    localparam logic [ADDR_W-1:0] OFS_DOORBELL = 8'h7C;
    localparam logic [ADDR_W-1:0] OFS_PENDING  = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 8'hA0;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DOORBELL,
        SEL_PENDING,
        SEL_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [BANK_IDX_W-1:0]  bank;
    } reg_sel_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] vector;
    } db_evt_t;

    function automatic reg_sel_t decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_t          s;
        logic [WORD_W-1:0] w;
        logic [WORD_W-1:0] pw;
        logic [WORD_W-1:0] mw;
        w  = a[ADDR_W-1:2];
        pw = OFS_PENDING[ADDR_W-1:2];
        mw = OFS_MASK[ADDR_W-1:2];
        s.kind = SEL_NONE;
        s.bank = '0;
        if (a[1:0] == 2'b00) begin
            if (w == OFS_DOORBELL[ADDR_W-1:2]) begin
                s.kind = SEL_DOORBELL;
            end else if (w >= pw && w < pw + WORD_W'(NUM_BANKS)) begin
                s.kind = SEL_PENDING;
                s.bank = BANK_IDX_W'(w - pw);
            end else if (w >= mw && w < mw + WORD_W'(NUM_BANKS)) begin
                s.kind = SEL_MASK;
                s.bank = BANK_IDX_W'(w - mw);
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/msi_vec_onehot.sv
module msi_vec_onehot
    import msi_dbc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  db_evt_t      evt,
    output logic [NUM_VEC-1:0] set_mask
);
    always_comb begin
        set_mask = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (evt.valid && evt.vector == DATA_W'(i)) set_mask[i] = 1'b1;
        end
    end

    AST_ONE_VECTOR_PER_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_mask)); // R1
    AST_OUT_OF_RANGE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.vector >= DATA_W'(NUM_VEC)) |-> (set_mask == '0)); // R3
endmodule

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_dbc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    input  logic [NUM_VEC-1:0]           pending,
    input  logic [NUM_VEC-1:0]           mask,
    output db_evt_t                      bus_db,
    output logic [NUM_BANKS-1:0]         clr_stb,
    output logic [NUM_BANKS-1:0]         msk_stb,
    output logic [DATA_W-1:0]            reg_rdata
);
    reg_sel_t          sel;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        sel = decode_offset(reg_addr);
        bus_db.valid  = reg_wr && sel.kind == SEL_DOORBELL;
        bus_db.vector = reg_wdata;
        for (int b = 0; b < NUM_BANKS; b++) begin
            clr_stb[b] = reg_wr && sel.kind == SEL_PENDING && sel.bank == BANK_IDX_W'(b);
            msk_stb[b] = reg_wr && sel.kind == SEL_MASK    && sel.bank == BANK_IDX_W'(b);
        end
    end

    always_comb begin
        rd_word = '0;
        case (sel.kind)
            SEL_PENDING: rd_word = DATA_W'(pending[sel.bank*BANK_W +: BANK_W]);
            SEL_MASK:    rd_word = DATA_W'(mask[sel.bank*BANK_W +: BANK_W]);
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_word;
        else             rdata_q <= '0;
    end

    assign reg_rdata = rdata_q;

    AST_SINGLE_BANK_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({clr_stb, msk_stb})); // R4
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> (reg_rdata == '0)); // R10
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank
    import msi_dbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] set_bits,
    input  logic              clr_stb,
    input  logic              msk_stb,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] pending,
    output logic [BANK_W-1:0] mask
);
    logic [BANK_W-1:0] clr_bits;

    assign clr_bits = clr_stb ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            mask    <= '0;
        end else begin
            pending <= (pending & ~clr_bits) | set_bits;
            if (msk_stb) mask <= wdata;
        end
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pending & $past(set_bits)) == $past(set_bits))); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pending & $past(clr_bits & ~set_bits)) == '0)); // R5
    AST_NO_SPONTANEOUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(pending) & ~$past(clr_bits) & ~pending) == '0)); // R5
    AST_MASK_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == '0 && pending == '0)); // R7
endmodule

// File: rtl/msi_irq_combine.sv
module msi_irq_combine
    import msi_dbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] pending,
    input  logic [NUM_VEC-1:0] mask,
    output logic               irq
);
    logic [NUM_BANKS-1:0] bank_hit;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
            assign bank_hit[b] = |(pending[b*BANK_W +: BANK_W] & mask[b*BANK_W +: BANK_W]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |bank_hit;
    end

    AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mask != '0)); // R8
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(pending != '0)); // R8
    AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq); // R7
endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
    import msi_dbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ib_db_valid,
    input  logic [DATA_W-1:0] ib_db_vector,
    output logic              irq_out
);
    db_evt_t              bus_db;
    db_evt_t              ib_db;
    logic [NUM_VEC-1:0]   set_bus;
    logic [NUM_VEC-1:0]   set_ib;
    logic [NUM_VEC-1:0]   set_all;
    logic [NUM_VEC-1:0]   pending;
    logic [NUM_VEC-1:0]   mask;
    logic [NUM_BANKS-1:0] clr_stb;
    logic [NUM_BANKS-1:0] msk_stb;

    assign ib_db.valid  = ib_db_valid;
    assign ib_db.vector = ib_db_vector;
    assign set_all      = set_bus | set_ib;

    msi_reg_decode i_decode (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pending   (pending),
        .mask      (mask),
        .bus_db    (bus_db),
        .clr_stb   (clr_stb),
        .msk_stb   (msk_stb),
        .reg_rdata (reg_rdata)
    );

    msi_vec_onehot i_bus_vec (
        .clk      (clk),
        .rst      (rst),
        .evt      (bus_db),
        .set_mask (set_bus)
    );

    msi_vec_onehot i_ib_vec (
        .clk      (clk),
        .rst      (rst),
        .evt      (ib_db),
        .set_mask (set_ib)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            msi_vec_bank i_bank (
                .clk      (clk),
                .rst      (rst),
                .set_bits (set_all[b*BANK_W +: BANK_W]),
                .clr_stb  (clr_stb[b]),
                .msk_stb  (msk_stb[b]),
                .wdata    (reg_wdata[BANK_W-1:0]),
                .pending  (pending[b*BANK_W +: BANK_W]),
                .mask     (mask[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    msi_irq_combine i_irq (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .mask    (mask),
        .irq     (irq_out)
    );

    AST_INBOUND_RAISES: assert property (@(posedge clk) disable iff (rst)
        (ib_db_valid && ib_db_vector < DATA_W'(NUM_VEC))
            |=> (pending[$past(ib_db_vector[VEC_IDX_W-1:0])] == 1'b1)); // R2
endmodule

// File: tb/test_msi_doorbell_ctrl.sv
module test_msi_doorbell_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ib_db_valid = 1'b0;
    logic [31:0] ib_db_vector = '0;
    logic        irq_out;

    logic [255:0] m_pend = '0;
    logic [255:0] m_mask = '0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    msi_doorbell_ctrl i_msi_doorbell_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ib_db_valid(ib_db_valid), .ib_db_vector(ib_db_vector), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a >= 8'h80 && a <= 8'h9C) return m_pend[(a - 8'h80) * 8 +: 32];
        if (a >= 8'hA0 && a <= 8'hBC) return m_mask[(a - 8'hA0) * 8 +: 32];
        return 32'h0;
    endfunction

    function automatic logic exp_irq();
        return |(m_pend & m_mask);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle, optional inbound doorbell in the same cycle; updates the model.
    task automatic cycle(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d,
                         input bit dbv, input logic [31:0] dbvec, output logic [31:0] rdv);
        logic [31:0] expr;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        ib_db_valid = dbv; ib_db_vector = dbvec;
        expr = exp_read(a);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; ib_db_valid = 1'b0;
        rdv = reg_rdata;
        if (rd) check("R10 read data", rdv, expr);
        if (wr && a[1:0] == 2'b00) begin
            if (a >= 8'h80 && a <= 8'h9C) m_pend[(a - 8'h80) * 8 +: 32] = m_pend[(a - 8'h80) * 8 +: 32] & ~d;
            if (a >= 8'hA0 && a <= 8'hBC) m_mask[(a - 8'hA0) * 8 +: 32] = d;
            if (a == 8'h7C && d < 256) m_pend[d[7:0]] = 1'b1;
        end
        if (dbv && dbvec < 256) m_pend[dbvec[7:0]] = 1'b1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] x;
        cycle(1'b1, 1'b0, a, d, 1'b0, 32'h0, x);
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] x;
        cycle(1'b0, 1'b1, a, 32'h0, 1'b0, 32'h0, x);
        check(req, x, exp);
    endtask

    task automatic ib_ring(input logic [31:0] v);
        logic [31:0] x;
        cycle(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, v, x);
    endtask

    task automatic settle_irq(input string req);
        @(negedge clk);
        check(req, {31'h0, irq_out}, {31'h0, exp_irq()});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] x;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check("R7 irq after reset", {31'h0, irq_out}, 32'h0);
        rd_check("R7 pending word0 after reset", 8'h80, 32'h0);
        rd_check("R7 mask word7 after reset", 8'hBC, 32'h0);
        // R1, R4, R11: bus doorbell on masked vector
        wr_reg(8'h7C, 32'd5);
        rd_check("R1 R4 bus doorbell vector 5", 8'h80, 32'h0000_0020);
        settle_irq("R11 masked pending keeps irq low");
        // R2, R4: inbound doorbell top vector
        ib_ring(32'd255);
        rd_check("R2 R4 inbound vector 255", 8'h9C, 32'h8000_0000);
        // R3: out-of-range values
        ib_ring(32'd256);
        ib_ring(32'hFFFF_FFFF);
        wr_reg(8'h7C, 32'd300);
        for (int b = 0; b < 8; b++)
            rd_check("R3 out of range ignored", 8'h80 + 8'(b * 4), exp_read(8'h80 + 8'(b * 4)));
        // R6, R8, R11: unmask vector 5; irq lags one edge
        wr_reg(8'hA0, 32'h0000_0020);
        check("R8 irq not yet raised", {31'h0, irq_out}, 32'h0);
        settle_irq("R8 R11 irq raised after unmask");
        rd_check("R6 mask readback", 8'hA0, 32'h0000_0020);
        // R5: zero write keeps, one write clears
        wr_reg(8'h80, 32'h0);
        rd_check("R5 zero write keeps bit", 8'h80, 32'h0000_0020);
        wr_reg(8'h80, 32'h0000_0020);
        check("R8 irq still high one edge", {31'h0, irq_out}, 32'h1);
        settle_irq("R5 R8 irq drops after ack");
        rd_check("R5 ack clears bit", 8'h80, 32'h0);
        // R9: same-cycle set and clear on vector 40
        ib_ring(32'd40);
        cycle(1'b1, 1'b0, 8'h84, 32'h0000_0100, 1'b1, 32'd40, x);
        rd_check("R9 set wins over clear", 8'h84, 32'h0000_0100);
        // R2: bus and inbound doorbells together
        cycle(1'b1, 1'b0, 8'h7C, 32'd64, 1'b1, 32'd65, x);
        rd_check("R2 dual doorbells", 8'h88, 32'h0000_0003);
        // R10: unmapped offsets
        rd_check("R10 unmapped 0x00", 8'h00, 32'h0);
        rd_check("R10 doorbell reads zero", 8'h7C, 32'h0);
        rd_check("R10 past mask array", 8'hC0, 32'h0);
        rd_check("R10 misaligned", 8'h85, 32'h0);
        // Random traffic against the model
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [31:0] v;
            logic [7:0]  a;
            op = int'($urandom_range(0, 5));
            case (op)
                0: ib_ring($urandom_range(0, 290));
                1: wr_reg(8'h7C, $urandom_range(0, 290));
                2: wr_reg(8'h80 + 8'($urandom_range(0, 7) * 4), $urandom);
                3: begin
                    v = $urandom & $urandom;
                    wr_reg(8'hA0 + 8'($urandom_range(0, 7) * 4), v);
                end
                4: begin
                    a = 8'($urandom_range(0, 255));
                    cycle(1'b0, 1'b1, a, 32'h0, 1'b0, 32'h0, x);
                end
                default: begin
                    a = 8'h80 + 8'($urandom_range(0, 7) * 4);
                    cycle(1'b1, 1'b0, a, $urandom, 1'b1, 32'($urandom_range(0, 255)), x);
                end
            endcase
            settle_irq("R8 random irq level");
        end
        for (int b = 0; b < 8; b++) begin
            rd_check("R4 final pending", 8'h80 + 8'(b * 4), exp_read(8'h80 + 8'(b * 4)));
            rd_check("R6 final mask", 8'hA0 + 8'(b * 4), exp_read(8'hA0 + 8'(b * 4)));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule